// File: doc/BRIEF.md
# Pipelined register replica propagator

This block keeps one copy of a single architectural register for every pipeline stage, together with a timestamp recording when that copy was written. On each clock edge it moves copies forward from stage to stage, feeds the write-back value back to the early stages and ahead to the late ones, and applies a fixed table of forwarding paths. A copy moves only when its timestamp is not older than the timestamp of the copy it replaces, so stale data never overwrites newer data.

The surrounding pipeline supplies the index of the stalled stage, a mask of stages holding bubbles in the current cycle and a mask of stages that will hold bubbles in the next cycle. Each stage can also overwrite its own copy through a write port. A write stamps the copy with the value of a free-running cycle counter. The read stage, the write-back stage, the forwarding table and the propagation mode are parameters. In the linked mode, the write-back stage feeds the stages around it. In the explicit mode, only stage-to-stage forward movement and the listed paths apply. A registered flag reports whether any copy moved on the previous edge.

The block has no state machine. Its only sequential state is the bank of copies, the cycle counter and the flag.

Top module: `rp_replica_prop`

## Requirements
- R1: While reset is asserted, every stage value and every timestamp reads zero and the change flag is low.
- R2: When a stage's write enable is high at a clock edge, that stage takes the write data and the counter value held before the edge. This write wins over any propagation into the same stage.
- R3: In linked mode, each stage from RD+1 through WB that is not written and not marked as a next-cycle bubble takes the previous stage's value and timestamp, if the previous timestamp is not older than its own.
- R4: The stall input is a signed stage index, where -1 means no stall. A stage whose index is not greater than the stall index keeps its contents instead of taking the previous stage's copy.
- R5: A stage in the forward range whose bit in the next-cycle bubble mask is set has its value and timestamp cleared to zero, unless a write or a forwarding path fills it.
- R6: In linked mode, if the write-back stage holds no bubble in the current cycle, its copy is written to every stage after it and to every stage from 0 through RD whose timestamp is not newer. A current bubble at the write-back stage blocks both moves.
- R7: Each forwarding path copies its source stage into its destination stage after the default moves. It does so only when the source holds no current bubble and the source timestamp is not older than the destination's pending timestamp.
- R8: Paths are listed in decreasing priority: entry 0 is the highest. When several paths reach the same destination, the highest-priority eligible path supplies the value.
- R9: The change flag is high in the cycle after an edge at which any forward, feed-forward, feed-back or path copy occurred. It is low after an edge with no such copy. Writes and bubble clears do not raise it.
- R10: In explicit mode, forward movement covers stages 1 through the last stage, and the write-back stage does not feed any other stage.
- R11: The counter reads 1 at the first edge after reset and increments on every edge. A stage's timestamp never decreases, except through a bubble clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | SW | Signed index of the stalled stage, -1 for none |
| cur_bub_i | input | N | Stages holding a bubble this cycle |
| nxt_bub_i | input | N | Stages that will hold a bubble next cycle |
| wr_en_i | input | N | Per-stage write enables |
| wr_data_i | input | N*DW | Per-stage write data, stage k at bits k*DW upward |
| val_o | output | N*DW | Stage copies, stage k at bits k*DW upward |
| ts_o | output | N*TW | Stage timestamps, stage k at bits k*TW upward |
| chg_o | output | 1 | Some copy moved on the previous edge |

## Verification
The bench builds two instances with five stages, the read stage at 1 and write-back at 3. Both carry two forwarding paths into stage 2, from stage 3 (higher priority) and from stage 4. This leaves one stage beyond write-back for the feed-forward, two stages in the feed-back range, and a destination that two paths contend for, so priority can be observed. The second instance uses the explicit mode, so the same stimulus shows that a value stays in stage 0 while the linked instance overwrites it.

// File: rtl/rp_pkg.sv
package rp_pkg;

    // Propagation variant: linked uses write-back feed-forward/feed-back,
    // explicit uses only stage-to-stage movement plus listed paths.
    typedef enum logic {
        PM_LINKED   = 1'b0,
        PM_EXPLICIT = 1'b1
    } prop_mode_e;

    // Width of a signed stage index able to hold -1 .. n-1.
    function automatic int stall_width(input int n);
        return $clog2(n) + 1;
    endfunction

endpackage

// File: rtl/rp_stamp_ctr.sv
module rp_stamp_ctr #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] cnt_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= TW'(1);
        else     cnt_q <= cnt_q + TW'(1);
    end

    assign cnt_o = cnt_q;

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + TW'(1));

endmodule

// File: rtl/rp_next_calc.sv
module rp_next_calc
    import rp_pkg::*;
#(
    parameter int         N    = 5,
    parameter int         DW   = 32,
    parameter int         TW   = 64,
    parameter int         RD   = 1,
    parameter int         WB   = 3,
    parameter int         NP   = 2,
    parameter int         SRC [NP] = '{3, 4},
    parameter int         DST [NP] = '{2, 2},
    parameter prop_mode_e MODE = PM_LINKED,
    parameter int         SW   = stall_width(N)
) (
    input  logic [DW-1:0]        cv_i [N],
    input  logic [TW-1:0]        ct_i [N],
    input  logic [TW-1:0]        cnt_i,
    input  logic signed [SW-1:0] stall_i,
    input  logic [N-1:0]         cur_bub_i,
    input  logic [N-1:0]         nxt_bub_i,
    input  logic [N-1:0]         wr_en_i,
    input  logic [DW-1:0]        wd_i [N],
    output logic [DW-1:0]        nv_o [N],
    output logic [TW-1:0]        nt_o [N],
    output logic                 moved_o
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int LO = (MODE == PM_EXPLICIT) ? 1     : RD + 1;
    localparam int HI = (MODE == PM_EXPLICIT) ? N - 1 : WB;

    always_comb begin
        nv_o    = cv_i;
        nt_o    = ct_i;
        moved_o = 1'b0;

        // Write-back feed-forward and feed-back, linked mode only.
        if (MODE == PM_LINKED && !cur_bub_i[IW'(WB)]) begin
            for (int i = WB + 1; i < N; i++) begin
                if (ct_i[WB] >= ct_i[i]) begin
                    nv_o[i] = cv_i[WB];
                    nt_o[i] = ct_i[WB];
                    moved_o = 1'b1;
                end
            end
            for (int i = 0; i <= RD; i++) begin
                if (ct_i[WB] >= ct_i[i]) begin
                    nv_o[i] = cv_i[WB];
                    nt_o[i] = ct_i[WB];
                    moved_o = 1'b1;
                end
            end
        end

        // Step-wise forward movement with bubble clear and stall hold.
        for (int i = LO; i <= HI; i++) begin
            if (nxt_bub_i[IW'(i)]) begin
                nv_o[i] = '0;
                nt_o[i] = '0;
            end else if (i > int'(stall_i) && ct_i[i-1] >= ct_i[i]) begin
                nv_o[i] = cv_i[i-1];
                nt_o[i] = ct_i[i-1];
                moved_o = 1'b1;
            end
        end

        // Forwarding paths, lowest priority first so entry 0 lands last.
        for (int p = NP - 1; p >= 0; p--) begin
            if (!cur_bub_i[IW'(SRC[p])] && ct_i[SRC[p]] >= nt_o[DST[p]]) begin
                nv_o[DST[p]] = cv_i[SRC[p]];
                nt_o[DST[p]] = ct_i[SRC[p]];
                moved_o      = 1'b1;
            end
        end

        // Stage writes override everything above.
        for (int i = 0; i < N; i++) begin
            if (wr_en_i[IW'(i)]) begin
                nv_o[i] = wd_i[i];
                nt_o[i] = cnt_i;
            end
        end
    end

endmodule

// File: rtl/rp_replica_prop.sv
module rp_replica_prop
    import rp_pkg::*;
#(
    parameter int         N    = 5,
    parameter int         DW   = 32,
    parameter int         TW   = 64,
    parameter int         RD   = 1,
    parameter int         WB   = 3,
    parameter int         NP   = 2,
    parameter int         SRC [NP] = '{3, 4},
    parameter int         DST [NP] = '{2, 2},
    parameter prop_mode_e MODE = PM_LINKED,
    parameter int         SW   = stall_width(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [SW-1:0] stall_i,
    input  logic [N-1:0]         cur_bub_i,
    input  logic [N-1:0]         nxt_bub_i,
    input  logic [N-1:0]         wr_en_i,
    input  logic [N*DW-1:0]      wr_data_i,
    output logic [N*DW-1:0]      val_o,
    output logic [N*TW-1:0]      ts_o,
    output logic                 chg_o
);

    localparam int LO = (MODE == PM_EXPLICIT) ? 1     : RD + 1;
    localparam int HI = (MODE == PM_EXPLICIT) ? N - 1 : WB;

    function automatic bit dst_hit(input int s);
        bit h = 1'b0;
        for (int p = 0; p < NP; p++) if (DST[p] == s) h = 1'b1;
        return h;
    endfunction

    logic [DW-1:0] val_q [N];
    logic [TW-1:0] ts_q  [N];
    logic [DW-1:0] nv    [N];
    logic [TW-1:0] nt    [N];
    logic [DW-1:0] wd    [N];
    logic [TW-1:0] cnt;
    logic          moved;
    logic          chg_q;

    rp_stamp_ctr #(.TW(TW)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .cnt_o (cnt)
    );

    rp_next_calc #(
        .N(N), .DW(DW), .TW(TW), .RD(RD), .WB(WB), .NP(NP),
        .SRC(SRC), .DST(DST), .MODE(MODE), .SW(SW)
    ) u_calc (
        .cv_i      (val_q),
        .ct_i      (ts_q),
        .cnt_i     (cnt),
        .stall_i   (stall_i),
        .cur_bub_i (cur_bub_i),
        .nxt_bub_i (nxt_bub_i),
        .wr_en_i   (wr_en_i),
        .wd_i      (wd),
        .nv_o      (nv),
        .nt_o      (nt),
        .moved_o   (moved)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                val_q[i] <= '0;
                ts_q[i]  <= '0;
            end
            chg_q <= 1'b0;
        end else begin
            val_q <= nv;
            ts_q  <= nt;
            chg_q <= moved;
        end
    end

    assign chg_o = chg_q;

    for (genvar g = 0; g < N; g++) begin : g_stage
        assign wd[g]               = wr_data_i[g*DW +: DW];
        assign val_o[g*DW +: DW]   = val_q[g];
        assign ts_o[g*TW +: TW]    = ts_q[g];

        // R2
        wr_stamp_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en_i[g] |=> ts_q[g] == $past(cnt) && val_q[g] == $past(wd[g]));

        // R11
        ts_mono_chk: assert property (@(posedge clk) disable iff (rst)
            !nxt_bub_i[g] |=> ts_q[g] >= $past(ts_q[g]));

        if (g >= LO && g <= HI && !dst_hit(g)) begin : g_clr
            // R5
            bub_clear_chk: assert property (@(posedge clk) disable iff (rst)
                nxt_bub_i[g] && !wr_en_i[g] |=> val_q[g] == '0 && ts_q[g] == '0);
        end
    end

endmodule

// File: tb/sim_rp_replica_prop.sv
module sim_rp_replica_prop;
    import rp_pkg::*;

    localparam int N  = 5;
    localparam int DW = 32;
    localparam int TW = 64;
    localparam int SW = stall_width(N);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [SW-1:0] stall = -1;
    logic [N-1:0]         cb = '0;
    logic [N-1:0]         nb = '0;
    logic [N-1:0]         we = '0;
    logic [N*DW-1:0]      wd = '0;
    logic [N*DW-1:0]      val0, val1;
    logic [N*TW-1:0]      ts0, ts1;
    logic                 chg0, chg1;
    logic [TW-1:0]        tcnt;
    int                   total = 0;
    int                   fails = 0;

    always #5 clk = ~clk;

    always @(posedge clk) tcnt <= rst ? TW'(1) : tcnt + TW'(1);

    rp_replica_prop u0 (
        .clk(clk), .rst(rst), .stall_i(stall), .cur_bub_i(cb), .nxt_bub_i(nb),
        .wr_en_i(we), .wr_data_i(wd), .val_o(val0), .ts_o(ts0), .chg_o(chg0)
    );

    rp_replica_prop #(.MODE(PM_EXPLICIT)) u1 (
        .clk(clk), .rst(rst), .stall_i(stall), .cur_bub_i(cb), .nxt_bub_i(nb),
        .wr_en_i(we), .wr_data_i(wd), .val_o(val1), .ts_o(ts1), .chg_o(chg1)
    );

    function automatic logic [DW-1:0] v0(input int s); return val0[s*DW +: DW]; endfunction
    function automatic logic [DW-1:0] v1(input int s); return val1[s*DW +: DW]; endfunction
    function automatic logic [TW-1:0] t0(input int s); return ts0[s*TW +: TW]; endfunction
    function automatic logic [TW-1:0] t1(input int s); return ts1[s*TW +: TW]; endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wrs(input int s, input logic [DW-1:0] d, output logic [TW-1:0] stamp);
        we[s] = 1'b1;
        wd[s*DW +: DW] = d;
        stamp = tcnt;
        step(1);
        we = '0;
    endtask

    task automatic t_reset;
        step(3);
        for (int s = 0; s < N; s++) begin
            chk("R1 value", 64'(v0(s)), 64'd0);
            chk("R1 stamp", t0(s), 64'd0);
        end
        chk("R1 flag", 64'(chg0), 64'd0);
        rst = 1'b0;
        step(3);
    endtask

    task automatic t_flow;
        logic [TW-1:0] sa;
        wrs(2, 32'hA1, sa);
        chk("R2 value", 64'(v0(2)), 64'hA1);
        chk("R2 stamp", t0(2), sa);
        chk("R3 not yet", 64'(v0(3)), 64'd0);
        step(1);
        chk("R3 forward", 64'(v0(3)), 64'hA1);
        step(1);
        chk("R6 ahead", 64'(v0(4)), 64'hA1);
        chk("R6 back", 64'(v0(0)), 64'hA1);
        chk("R11 stamp carried", t0(0), sa);
        step(2);
    endtask

    task automatic t_stall;
        logic [TW-1:0] sb;
        stall = 3;
        wrs(2, 32'hB2, sb);
        step(1);
        chk("R4 held", 64'(v0(3)), 64'hA1);
        chk("R4 source", 64'(v0(2)), 64'hB2);
        stall = -1;
        step(1);
        chk("R4 released", 64'(v0(3)), 64'hB2);
        step(3);
    endtask

    task automatic t_bub_next;
        nb[3] = 1'b1;
        step(1);
        nb = '0;
        chk("R5 value", 64'(v0(3)), 64'd0);
        chk("R5 stamp", t0(3), 64'd0);
        chk("R6 ahead old", 64'(v0(4)), 64'hB2);
        step(1);
        chk("R5 refill", 64'(v0(3)), 64'hB2);
        step(2);
    endtask

    task automatic t_bub_now;
        logic [TW-1:0] sc;
        wrs(3, 32'hC3, sc);
        cb[3] = 1'b1;
        step(1);
        cb = '0;
        chk("R6 back blocked", 64'(v0(0)), 64'hB2);
        chk("R6 ahead blocked", 64'(v0(4)), 64'hB2);
        chk("R7 path blocked", 64'(v0(2)), 64'hB2);
        step(1);
        chk("R7 path", 64'(v0(2)), 64'hC3);
        chk("R6 back", 64'(v0(0)), 64'hC3);
        chk("R6 ahead", 64'(v0(4)), 64'hC3);
        step(2);
    endtask

    task automatic t_prio;
        we[3] = 1'b1; wd[3*DW +: DW] = 32'hD4;
        we[4] = 1'b1; wd[4*DW +: DW] = 32'hE5;
        step(1);
        we = '0;
        step(1);
        chk("R8 priority", 64'(v0(2)), 64'hD4);
        chk("R6 ahead", 64'(v0(4)), 64'hD4);
        step(3);
    endtask

    task automatic t_flag;
        step(1);
        chk("R9 high", 64'(chg0), 64'd1);
        stall = 4;
        cb = 5'b11000;
        step(1);
        chk("R9 low", 64'(chg0), 64'd0);
        chk("R9 no move", 64'(v0(2)), 64'hD4);
        stall = -1;
        cb = '0;
        step(1);
        chk("R9 high again", 64'(chg0), 64'd1);
        step(1);
    endtask

    task automatic t_explicit;
        logic [TW-1:0] sz;
        logic [TW-1:0] sw;
        wrs(0, 32'hF6, sz);
        step(3);
        chk("R10 stage3", 64'(v1(3)), 64'hF6);
        chk("R10 stage4 not yet", 64'(v1(4) == 32'hF6), 64'd0);
        step(1);
        chk("R10 stage4", 64'(v1(4)), 64'hF6);
        chk("R10 stamp", t1(4), sz);
        wrs(3, 32'h77, sw);
        step(2);
        chk("R6 linked back", 64'(v0(0)), 64'h77);
        chk("R10 no back", 64'(v1(0)), 64'hF6);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #1ms;
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_flow();
        t_stall();
        t_bub_next();
        t_bub_now();
        t_prio();
        t_flag();
        t_explicit();
        summary();
        $finish;
    end

endmodule